// File: doc/BRIEF.md
# Mixed-Sign Single-Cycle Integer Multiplier

This block multiplies two 16-bit integer operands for a 16-bit datapath and returns a 32-bit product one clock later. Each operand has its own signedness select, so one multiplier handles unsigned×unsigned, signed×signed and both mixed-sign combinations. The usual mixed case treats the first operand as signed and the second as unsigned. The operands are never swapped.

A single 17×17 signed array does all the work. Each operand is widened by one bit. That extra bit copies the operand's top bit when the operand is signed and is zero when it is unsigned. The array therefore always sees two correctly valued signed numbers. A size select chooses between word products and byte products. In byte mode only the low eight bits of each operand take part, widened the same way. The low 32 bits of the array's signed result come out already correctly extended.

The product is registered only when the valid strobe is high, and the valid flag follows the strobe by one clock. An active-low asynchronous reset clears both.

Top module: `mixed_sign_mul`

## Requirements
- R1: While rst_ni is low, and after it is released with no valid input, valid_o is 0 and prod_o is 0.
- R2: With a_signed_i=0 and b_signed_i=0 in word mode (byte_mode_i=0), prod_o equals the unsigned product of a_i and b_i, for example 0xFFFF×0xFFFF gives 0xFFFE0001.
- R3: With both signed selects at 1 in word mode, prod_o is the 32-bit two's-complement product, for example 0x8000×0x8000 gives 0x40000000.
- R4: With a_signed_i=1 and b_signed_i=0, a_i is read as signed and b_i as unsigned, for example 0x8000×0xFFFF gives 0x80008000. The reverse combination, with a_signed_i=0 and b_signed_i=1, reads a_i as unsigned and b_i as signed.
- R5: With byte_mode_i=1, only bits [7:0] of each operand are used, and bits [15:8] have no effect. Each byte is read as signed or unsigned by its own select, and the 16-bit result is sign-extended or zero-extended to 32 bits. An unsigned×unsigned byte product has prod_o[31:16]=0.
- R6: valid_o is 1 exactly one clock after a cycle in which valid_i is 1, and 0 one clock after a cycle in which valid_i is 0. prod_o shows the result for the inputs sampled in that valid cycle.
- R7: In a cycle with valid_i=0, prod_o keeps its previous value whatever the operand and select inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid this cycle |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| a_signed_i | input | 1 | 1: first operand is two's complement |
| b_signed_i | input | 1 | 1: second operand is two's complement |
| byte_mode_i | input | 1 | 1: multiply bits [7:0] only |
| valid_o | output | 1 | Product register holds a new result |
| prod_o | output | 32 | Registered product |

## Verification
A wrong extension bit appears on the port as a product that is off by a multiple of 2^16 or 2^8. It is visible one clock after the strobe, and only for operands whose top bit is set. For that reason the directed cases put 0x8000, 0xFFFF and 0x80 in each operand position under each signedness pairing. A product register that loads without a strobe shows up at the first idle cycle with changed operands, so every product is followed by such a cycle and checked for hold.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned PART_W_DEF = 8;

  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } mul_size_e;
endpackage

// File: rtl/mul_opnd_ext.sv
module mul_opnd_ext #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PART_W = 8,
  localparam int unsigned EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0]        d_i,
  input  logic                     sgn_i,
  input  mul_pkg::mul_size_e       size_i,
  output logic signed [EXT_W-1:0]  x_o
);
  logic fill_word, fill_part;

  assign fill_word = sgn_i & d_i[DATA_W-1];
  assign fill_part = sgn_i & d_i[PART_W-1];

  always_comb begin
    if (size_i == mul_pkg::SZ_BYTE) x_o = {{(EXT_W-PART_W){fill_part}}, d_i[PART_W-1:0]};
    else                            x_o = {fill_word, d_i};
  end
endmodule

// File: rtl/mul_array.sv
module mul_array #(
  parameter int unsigned EXT_W = 17,
  localparam int unsigned PROD_W = 2 * EXT_W
) (
  input  logic signed [EXT_W-1:0]  x_i,
  input  logic signed [EXT_W-1:0]  y_i,
  output logic signed [PROD_W-1:0] p_o
);
  logic signed [PROD_W-1:0] xw, yw;

  assign xw  = PROD_W'(x_i);
  assign yw  = PROD_W'(y_i);
  assign p_o = xw * yw;

  // R2: two non-negative extended operands never give a negative product
  always_comb begin
    if (!x_i[EXT_W-1] && !y_i[EXT_W-1])
      a_r2_nonneg_prod: assert (!p_o[PROD_W-1] || $isunknown({x_i, y_i}));
  end
endmodule

// File: rtl/mixed_sign_mul.sv
module mixed_sign_mul #(
  parameter int unsigned DATA_W = mul_pkg::DATA_W_DEF,
  parameter int unsigned PART_W = mul_pkg::PART_W_DEF,
  localparam int unsigned EXT_W  = DATA_W + 1,
  localparam int unsigned PROD_W = 2 * EXT_W,
  localparam int unsigned OUT_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  input  logic              byte_mode_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  prod_o
);
  mul_pkg::mul_size_e       size;
  logic signed [EXT_W-1:0]  a_ext, b_ext;
  logic signed [PROD_W-1:0] prod_full;
  logic [PROD_W-OUT_W-1:0]  unused_hi;

  assign size      = byte_mode_i ? mul_pkg::SZ_BYTE : mul_pkg::SZ_WORD;
  assign unused_hi = prod_full[PROD_W-1:OUT_W];

  mul_opnd_ext #(.DATA_W(DATA_W), .PART_W(PART_W)) i_ext_a (
    .d_i(a_i), .sgn_i(a_signed_i), .size_i(size), .x_o(a_ext)
  );

  mul_opnd_ext #(.DATA_W(DATA_W), .PART_W(PART_W)) i_ext_b (
    .d_i(b_i), .sgn_i(b_signed_i), .size_i(size), .x_o(b_ext)
  );

  mul_array #(.EXT_W(EXT_W)) i_array (
    .x_i(a_ext), .y_i(b_ext), .p_o(prod_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) prod_o <= prod_full[OUT_W-1:0];
    end
  end

  a_r6_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r6_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prod_o));

  a_r5_byte_unsigned_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && byte_mode_i && !a_signed_i && !b_signed_i) |=> (prod_o[OUT_W-1:2*PART_W] == '0));
endmodule

// File: tb/test_mixed_sign_mul.sv
`timescale 1ns/1ps
module test_mixed_sign_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        as = 1'b0, bs = 1'b0, bm = 1'b0;
  logic        valid_o;
  logic [31:0] prod_o;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mixed_sign_mul i_mixed_sign_mul (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .a_i(a), .b_i(b),
    .a_signed_i(as), .b_signed_i(bs), .byte_mode_i(bm),
    .valid_o(valid_o), .prod_o(prod_o)
  );

  function automatic logic [31:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic xs, input logic ys, input logic byt);
    longint vx, vy;
    if (byt) begin
      vx = xs ? longint'($signed(x[7:0])) : longint'(x[7:0]);
      vy = ys ? longint'($signed(y[7:0])) : longint'(y[7:0]);
    end else begin
      vx = xs ? longint'($signed(x)) : longint'(x);
      vy = ys ? longint'($signed(y)) : longint'(y);
    end
    return 32'(vx * vy);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One product then one idle cycle with disturbed operands
  task automatic run_mul(input string req, input logic [15:0] x, input logic [15:0] y,
                         input logic xs, input logic ys, input logic byt);
    logic [31:0] exp;
    exp = model(x, y, xs, ys, byt);
    @(negedge clk);
    a = x; b = y; as = xs; bs = ys; bm = byt; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    check({req, " R6 valid"}, 32'(valid_o), 32'd1);
    check(req, prod_o, exp);
    a = ~x; b = x ^ y; as = ~xs; bm = ~byt;
    @(negedge clk);
    check({req, " R6 idle"}, 32'(valid_o), 32'd0);
    check({req, " R7 hold"}, prod_o, exp);
  endtask

  task automatic t_reset;
    check("R1 valid in reset", 32'(valid_o), 32'd0);
    check("R1 prod in reset", prod_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    a = 16'h1234; b = 16'h5678;
    @(negedge clk);
    check("R1 valid after release", 32'(valid_o), 32'd0);
    check("R1 prod after release", prod_o, 32'd0);
  endtask

  task automatic t_unsigned;
    run_mul("R2 max", 16'hFFFF, 16'hFFFF, 0, 0, 0);
    check("R2 max literal", prod_o, 32'hFFFE0001);
    run_mul("R2 mid", 16'h8000, 16'h0003, 0, 0, 0);
    run_mul("R2 zero", 16'h0000, 16'hBEEF, 0, 0, 0);
  endtask

  task automatic t_signed;
    run_mul("R3 min*min", 16'h8000, 16'h8000, 1, 1, 0);
    check("R3 min*min literal", prod_o, 32'h40000000);
    run_mul("R3 neg*pos", 16'hFFFF, 16'h7FFF, 1, 1, 0);
    run_mul("R3 neg*neg", 16'hFF00, 16'hFFFE, 1, 1, 0);
  endtask

  task automatic t_mixed;
    run_mul("R4 su corner", 16'h8000, 16'hFFFF, 1, 0, 0);
    check("R4 su literal", prod_o, 32'h80008000);
    run_mul("R4 su pos", 16'h7FFF, 16'hFFFF, 1, 0, 0);
    run_mul("R4 us", 16'hFFFF, 16'h8000, 0, 1, 0);
  endtask

  task automatic t_byte;
    run_mul("R5 ss", 16'hAB80, 16'h12FF, 1, 1, 1);
    check("R5 ss literal", prod_o, 32'h00000080);
    run_mul("R5 uu", 16'hFFFF, 16'hFFFF, 0, 0, 1);
    check("R5 uu literal", prod_o, 32'h0000FE01);
    run_mul("R5 su", 16'h0080, 16'hA5FF, 1, 0, 1);
    check("R5 su literal", prod_o, 32'hFFFF8080);
    run_mul("R5 us", 16'h00FF, 16'h0080, 0, 1, 1);
  endtask

  task automatic t_burst;
    logic [31:0] e1, e2;
    e1 = model(16'h0101, 16'h0202, 0, 0, 0);
    e2 = model(16'hF000, 16'h0010, 1, 1, 0);
    @(negedge clk);
    a = 16'h0101; b = 16'h0202; as = 0; bs = 0; bm = 0; valid = 1'b1;
    @(negedge clk);
    check("R6 burst first", prod_o, e1);
    a = 16'hF000; b = 16'h0010; as = 1; bs = 1;
    @(negedge clk);
    valid = 1'b0;
    check("R6 burst second valid", 32'(valid_o), 32'd1);
    check("R6 burst second", prod_o, e2);
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_unsigned();
    t_signed();
    t_mixed();
    t_byte();
    t_burst();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule